// File: doc/BRIEF.md
# Multi-counter event performance monitor

The block watches a vector of single-cycle event pulses and keeps sixteen free-running 48-bit counters. Each counter is told which event to follow by an 8-bit event code. A counter only advances while the global run bit and its own enable bit are both set. Software can load any counter with a start value and read it back through a register bus.

When a counter wraps past its maximum, it sets its own bit in an overflow status register. That bit stays set until software clears it by writing 1 to it. A single level interrupt goes high while any overflowed counter has its mask bit at 0. Reset leaves every mask bit at 1, so all interrupts start masked.

The bus takes one request per cycle. Control, select and interrupt registers are 32 bits wide and use the low half of the data word. Counters are 64-bit words, and the top 16 bits of each counter word are reserved.

Top module: `evmon_top`

## Requirements
- R1: After reset:
  - every counter, the run bit, the enable register and the status register read 0;
  - the mask register reads 0x0000FFFF;
  - each of the four select registers reads 0xFFFFFFFF;
  - `irq` is 0.
- R2: Counter n sits at address 0x1F00 + 8*n. A write loads `bus_wdata[47:0]` and ignores bits 63:48. A read returns the 48-bit value with bits 63:48 as zero.
- R3: Select registers:
  - The code for counter n is in the select register at 0x1E80 + 4*(n/4), bits 8*(n%4)+7 down to 8*(n%4).
  - A code below 0x50 makes the counter follow `ev_pulse[code]`.
  - The code 0xFF, and any code of 0x50 or above, never makes the counter advance.
- R4: Bit 0 of the register at 0x1E00 is the global run bit. While it is 0, no counter advances.
- R5: Bit n of the register at 0x1E04 enables counter n. While that bit is 0, counter n does not advance.
- R6: An enabled counter advances by exactly 1 in each cycle in which its selected event pulses. Past 0xFFFFFFFFFFFF it wraps to 0 and keeps counting.
- R7: `irq` is high exactly while some counter n has status bit n set and bit n of the mask register at 0x0804 at 0.
- R8: Status register at 0x0808:
  - Bit n sets when counter n wraps, whether or not the counter is masked.
  - Once set, the bit stays set.
  - Writing 1 to bit n of the register at 0x080C clears it. Writing 0 to a bit of 0x080C leaves that bit unchanged.
- R9: If a software write to a counter and an increment of that counter fall in the same cycle, the written value is kept and the increment is dropped.
- R10: Bus timing:
  - A read returns its data on `rsp_rdata` with `rsp_valid` high in the following cycle.
  - A write takes effect from the following cycle.
  - An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request strobe, one request per cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 16 | Byte address of the request |
| bus_wdata | input | 64 | Write data; 32-bit registers use bits 31:0 |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 64 | Read data |
| ev_pulse | input | 80 | Event pulse inputs, one bit per event code |
| irq | output | 1 | Level overflow interrupt |

## Verification
The checker tests several rules on every cycle:
- all counters hold still while the run bit is low and no write is in flight;
- counter 0 holds while its enable bit is low;
- counter 0 never moves by more than one step except by a write;
- status bits never drop without a clear write;
- `irq` stays low while all mask bits are set.

Only the bench scenarios can show the rest:
- the byte-lane placement of event codes;
- the rejection of 0xFF and out-of-range codes;
- the exact counts and wrap value;
- write priority over a simultaneous increment;
- the read-as-zero upper counter bits;
- the unmask and clear sequence of the interrupt.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
    localparam int ADDR_W    = 16;
    localparam int BUS_W     = 32;
    localparam int WIDE_W    = 64;

    localparam logic [ADDR_W-1:0] OFF_IMASK = 16'h0804;
    localparam logic [ADDR_W-1:0] OFF_ISTAT = 16'h0808;
    localparam logic [ADDR_W-1:0] OFF_ICLR  = 16'h080C;
    localparam logic [ADDR_W-1:0] OFF_RUN   = 16'h1E00;
    localparam logic [ADDR_W-1:0] OFF_EN    = 16'h1E04;
    localparam logic [ADDR_W-1:0] OFF_SEL   = 16'h1E80;
    localparam logic [ADDR_W-1:0] OFF_CNT   = 16'h1F00;
endpackage

// File: rtl/evmon_counter.sv
module evmon_counter #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (ld) begin
            cnt_d = ld_val;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
            wrap  = &cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/evmon_event_sel.sv
module evmon_event_sel #(
    parameter int NUM_CNT = 16,
    parameter int NUM_EV  = 80,
    parameter int CODE_W  = 8
) (
    input  logic                           run,
    input  logic [NUM_CNT-1:0]             en,
    input  logic [NUM_CNT-1:0][CODE_W-1:0] sel,
    input  logic [NUM_EV-1:0]              ev,
    output logic [NUM_CNT-1:0]             inc
);
    localparam int CODE_SPACE = 1 << CODE_W;

    logic [CODE_SPACE-1:0] ev_pad;
    assign ev_pad = {{(CODE_SPACE-NUM_EV){1'b0}}, ev};

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_sel
        logic code_ok;
        assign code_ok = (int'(sel[n]) < NUM_EV);
        assign inc[n]  = run & en[n] & code_ok & ev_pad[sel[n]];
    end
endmodule

// File: rtl/evmon_regs.sv
module evmon_regs
    import evmon_pkg::*;
#(
    parameter int NUM_CNT = 16,
    parameter int CODE_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_stb,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [BUS_W-1:0]               wr_data,
    input  logic [NUM_CNT-1:0]             wrap,
    output logic                           run,
    output logic [NUM_CNT-1:0]             en,
    output logic [NUM_CNT-1:0]             mask,
    output logic [NUM_CNT-1:0]             status,
    output logic [NUM_CNT-1:0][CODE_W-1:0] sel
);
    localparam int LANES = BUS_W / CODE_W;
    localparam int NSEL  = NUM_CNT / LANES;

    typedef struct packed {
        logic                           run;
        logic [NUM_CNT-1:0]             en;
        logic [NUM_CNT-1:0]             mask;
        logic [NUM_CNT-1:0]             stat;
        logic [NUM_CNT-1:0][CODE_W-1:0] sel;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        logic [NUM_CNT-1:0] clr;
        st_d = st_q;
        clr  = '0;
        if (wr_stb) begin
            case (wr_addr)
                OFF_RUN:   st_d.run  = wr_data[0];
                OFF_EN:    st_d.en   = wr_data[NUM_CNT-1:0];
                OFF_IMASK: st_d.mask = wr_data[NUM_CNT-1:0];
                OFF_ICLR:  clr       = wr_data[NUM_CNT-1:0];
                default: ;
            endcase
            for (int g = 0; g < NSEL; g++) begin
                if (wr_addr == ADDR_W'(OFF_SEL + 4 * g)) begin
                    st_d.sel[g*LANES +: LANES] = wr_data[LANES*CODE_W-1:0];
                end
            end
        end
        st_d.stat = (st_q.stat & ~clr) | wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run  <= 1'b0;
            st_q.en   <= '0;
            st_q.mask <= '1;
            st_q.stat <= '0;
            st_q.sel  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign run    = st_q.run;
    assign en     = st_q.en;
    assign mask   = st_q.mask;
    assign status = st_q.stat;
    assign sel    = st_q.sel;
endmodule

// File: rtl/evmon_top.sv
module evmon_top
    import evmon_pkg::*;
#(
    parameter int NUM_CNT = 16,
    parameter int CNT_W   = 48,
    parameter int NUM_EV  = 80,
    parameter int CODE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [15:0]       bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    input  logic [NUM_EV-1:0] ev_pulse,
    output logic              irq
);
    localparam int IDX_W   = $clog2(NUM_CNT);
    localparam int SPAN_W  = IDX_W + 3;
    localparam int LANES   = BUS_W / CODE_W;
    localparam int NSEL    = NUM_CNT / LANES;

    typedef struct packed {
        logic              valid;
        logic [WIDE_W-1:0] data;
    } rsp_t;

    logic                           run;
    logic [NUM_CNT-1:0]             en, mask, status, inc, wrap, ld;
    logic [NUM_CNT-1:0][CODE_W-1:0] sel;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;
    logic                           wr_stb, cnt_hit;
    logic [IDX_W-1:0]               cnt_idx;
    rsp_t                           rsp_d, rsp_q;

    assign wr_stb  = bus_valid & bus_write;
    assign cnt_hit = (bus_addr[ADDR_W-1:SPAN_W] == OFF_CNT[ADDR_W-1:SPAN_W])
                   & (bus_addr[2:0] == 3'b000);
    assign cnt_idx = bus_addr[SPAN_W-1:3];

    evmon_regs #(.NUM_CNT(NUM_CNT), .CODE_W(CODE_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(bus_addr),
        .wr_data(bus_wdata[BUS_W-1:0]), .wrap(wrap), .run(run), .en(en),
        .mask(mask), .status(status), .sel(sel)
    );

    evmon_event_sel #(.NUM_CNT(NUM_CNT), .NUM_EV(NUM_EV), .CODE_W(CODE_W)) evsel_i (
        .run(run), .en(en), .sel(sel), .ev(ev_pulse), .inc(inc)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        assign ld[n] = wr_stb & cnt_hit & (cnt_idx == IDX_W'(n));
        evmon_counter #(.W(CNT_W)) cnt_i (
            .clk(clk), .rst_n(rst_n), .inc(inc[n]), .ld(ld[n]),
            .ld_val(bus_wdata[CNT_W-1:0]), .cnt(cnt[n]), .wrap(wrap[n])
        );
    end

    always_comb begin
        logic [WIDE_W-1:0] rd;
        rd = '0;
        if (cnt_hit) begin
            rd = WIDE_W'(cnt[cnt_idx]);
        end else begin
            case (bus_addr)
                OFF_RUN:   rd = WIDE_W'(run);
                OFF_EN:    rd = WIDE_W'(en);
                OFF_IMASK: rd = WIDE_W'(mask);
                OFF_ISTAT: rd = WIDE_W'(status);
                default: ;
            endcase
            for (int g = 0; g < NSEL; g++) begin
                if (bus_addr == ADDR_W'(OFF_SEL + 4 * g)) begin
                    rd = WIDE_W'(sel[g*LANES +: LANES]);
                end
            end
        end
        rsp_d.valid = bus_valid & ~bus_write;
        rsp_d.data  = (bus_valid & ~bus_write) ? rd : rsp_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;
    assign irq       = |(status & ~mask);
endmodule

// File: rtl/evmon_checker.sv
module evmon_checker #(
    parameter int NUM_CNT = 16,
    parameter int CNT_W   = 48
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_valid,
    input logic                          bus_write,
    input logic [15:0]                   bus_addr,
    input logic                          run,
    input logic [NUM_CNT-1:0]            en,
    input logic [NUM_CNT-1:0]            mask,
    input logic [NUM_CNT-1:0]            status,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt,
    input logic                          irq
);
    logic any_wr, clr_wr, cnt0_wr;
    assign any_wr  = bus_valid & bus_write;
    assign clr_wr  = any_wr & (bus_addr == 16'h080C);
    assign cnt0_wr = any_wr & (bus_addr == 16'h1F00);

    p_run_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !any_wr) |=> $stable(cnt))
        else $error("run bit low but a counter moved");

    p_en_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en[0] && !any_wr) |=> $stable(cnt[0]))
        else $error("counter 0 moved while disabled");

    p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt0_wr |=> ((cnt[0] == $past(cnt[0])) || (cnt[0] == $past(cnt[0]) + 1'b1)))
        else $error("counter 0 moved by more than one");

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq)
        else $error("interrupt while fully masked");

    p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((status & $past(status)) == $past(status)))
        else $error("status bit dropped without clear");
endmodule

bind evmon_top evmon_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .run(run), .en(en), .mask(mask), .status(status),
    .cnt(cnt), .irq(irq)
);

// File: tb/evmon_top_tb_top.sv
module evmon_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [79:0] ev_pulse = '0;
    logic        irq;

    int compared = 0;
    int mismatched = 0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    evmon_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .ev_pulse(ev_pulse), .irq(irq)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check("R10 unexpected response", 64'd1, 64'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, rsp_rdata, it.exp);
            end
        end
    end

    task automatic wr(logic [15:0] a, logic [63:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic [63:0] e, string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic pulse(logic [79:0] v, int n);
        for (int i = 0; i < n; i++) begin
            ev_pulse = v;
            @(negedge clk);
            ev_pulse = '0;
        end
    endtask

    function automatic logic [79:0] one_ev(int k);
        logic [79:0] v;
        v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired R10");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R1 irq after reset", 64'(irq), 64'd0);
        rd(16'h1F00, 64'd0, "R1 counter0 reset");
        rd(16'h1F78, 64'd0, "R1 counter15 reset");
        rd(16'h1E00, 64'd0, "R1 run reset");
        rd(16'h1E04, 64'd0, "R1 enable reset");
        rd(16'h0804, 64'h0000_FFFF, "R1 mask reset");
        rd(16'h0808, 64'd0, "R1 status reset");
        rd(16'h1E80, 64'hFFFF_FFFF, "R1 select0 reset");
        rd(16'h1E8C, 64'hFFFF_FFFF, "R1 select3 reset");
        rd(16'h1000, 64'd0, "R10 unmapped reads zero");

        // codes: cnt0=0x03, cnt1=0x4F, cnt2=0xFF, cnt3=0x50
        wr(16'h1E80, 64'h50FF_4F03);
        wr(16'h1E04, 64'h000F);
        wr(16'h1E00, 64'h1);
        rd(16'h1E80, 64'h50FF_4F03, "R3 select readback");
        rd(16'h1E00, 64'd1, "R4 run readback");
        pulse(one_ev(3), 5);
        pulse(one_ev(8'h4F), 2);
        pulse('1, 1);
        wr(16'h1E00, 64'h0);
        rd(16'h1F00, 64'd6, "R6 counter0 counts event 3");
        rd(16'h1F08, 64'd3, "R3 counter1 follows top code 0x4F");
        rd(16'h1F10, 64'd0, "R3 code 0xFF never counts");
        rd(16'h1F18, 64'd0, "R3 code 0x50 never counts");

        pulse('1, 3);
        rd(16'h1F00, 64'd6, "R4 run low holds counter0");
        rd(16'h1F08, 64'd3, "R4 run low holds counter1");

        wr(16'h1E04, 64'h000E);
        wr(16'h1E00, 64'h1);
        pulse('1, 1);
        rd(16'h1F00, 64'd6, "R5 disabled counter0 holds");
        rd(16'h1F08, 64'd4, "R5 enabled counter1 counts");

        wr(16'h1F08, 64'hABCD_0000_0000_0012);
        rd(16'h1F08, 64'h12, "R2 upper write bits ignored");
        wr(16'h1F08, 64'h0000_8765_4321_0FED);
        rd(16'h1F08, 64'h0000_8765_4321_0FED, "R2 full 48-bit load");

        wr(16'h1E84, 64'hFFFF_FF07);
        wr(16'h1F20, 64'h0000_FFFF_FFFF_FFFE);
        wr(16'h1E04, 64'h001E);
        pulse(one_ev(7), 1);
        rd(16'h1F20, 64'h0000_FFFF_FFFF_FFFF, "R6 counter4 at maximum");
        rd(16'h0808, 64'd0, "R8 no status before wrap");
        pulse(one_ev(7), 1);
        rd(16'h1F20, 64'd0, "R6 counter4 wraps to zero");
        rd(16'h0808, 64'h10, "R8 status set while masked");
        check("R7 irq low while masked", 64'(irq), 64'd0);
        wr(16'h0804, 64'hFFEF);
        check("R7 irq high once unmasked", 64'(irq), 64'd1);
        pulse(one_ev(7), 1);
        rd(16'h1F20, 64'd1, "R6 counter4 keeps running after wrap");
        wr(16'h080C, 64'h0);
        rd(16'h0808, 64'h10, "R8 writing zero keeps status");
        wr(16'h080C, 64'h10);
        rd(16'h0808, 64'd0, "R8 write one clears status");
        check("R7 irq low after clear", 64'(irq), 64'd0);

        wr(16'h1F08, 64'd50);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 16'h1F08; bus_wdata = 64'd100;
        ev_pulse = one_ev(8'h4F);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; ev_pulse = '0;
        rd(16'h1F08, 64'd100, "R9 write beats increment");
        pulse(one_ev(8'h4F), 1);
        rd(16'h1F08, 64'd101, "R9 counting resumes after write");

        repeat (4) @(negedge clk);
        check("R10 all responses seen", 64'(sb_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule